// File: doc/BRIEF.md
# Power-Fail Bus Gate for a Battery-Backed SRAM

This block sits between an asynchronous SRAM-style control bus and the storage array of a battery-backed memory. It samples two chip enables (one active-low, one active-high), an output enable and a write enable on the system clock. From these it produces registered write and read status: write-active, write-start and write-commit, output-drive enable and read-start. All of these are gated by two power flags that external comparators supply. One flag says the supply is above the deselect threshold. The other says it is above the battery switchover threshold.

While the supply is below the deselect threshold, the bus is dead. No write is accepted, the data outputs are never driven, and a write in flight is dropped without a commit pulse. After the supply comes back, write protection is held for a programmable number of clock cycles. The count starts over whenever the good-supply flag drops during it. A separate registered output selects the battery while the supply is below the switchover threshold. The block has no data path, so every pin is a plain level or a one-cycle pulse. None of them needs a valid/ready handshake or back-pressure.

Top module: `pwrfail_bus_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_protect` and `batt_sel` are 1, and `wr_active`, `wr_start`, `wr_commit`, `drive_en` and `rd_start` are 0.
- R2: When `en_n`=0, `en`=1 and `wr_n`=0 are sampled at a clock edge while the bus is live (`vdd_ok`=1 and not protected), `wr_active` is 1 after that edge. `wr_start` pulses for exactly the first such cycle.
- R3: A write ends at the first edge where `wr_n`=1, `en_n`=1 or `en`=0 is sampled. If `vdd_ok` is 1 at that edge, `wr_commit` is 1 for that one cycle.
- R4: When `en_n`=0, `en`=1, `wr_n`=1 and `oe_n`=0 are sampled on a live bus, `drive_en` is 1 after the edge. `rd_start` pulses for the first such cycle.
- R5: Sampling `wr_n`=0 clears `drive_en` at that edge. An enable that becomes active while `wr_n` is 0 starts a write and never drives the outputs.
- R6: A sample of `vdd_ok`=0 sets `wr_protect` and clears `wr_active`, `wr_start`, `drive_en` and `rd_start` at that edge. All control inputs are ignored while that condition lasts.
- R7: A write that is active when `vdd_ok`=0 is sampled is aborted: `wr_active` falls, and `wr_commit` stays 0.
- R8: `wr_protect` clears only after `vdd_ok`=1 has been sampled at RECOVER_CYCLES consecutive edges. A 0 sample restarts the count. While protected, bus requests are ignored.
- R9: After each edge, `batt_sel` equals the inverse of the sampled `vdd_swo_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low chip enable |
| en | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write enable |
| vdd_ok | input | 1 | Supply above deselect threshold |
| vdd_swo_ok | input | 1 | Supply above battery switchover threshold |
| wr_active | output | 1 | Write cycle in progress |
| wr_start | output | 1 | One-cycle pulse at write start |
| wr_commit | output | 1 | One-cycle pulse at a clean write end |
| drive_en | output | 1 | Data output drive enable |
| rd_start | output | 1 | One-cycle pulse at read start |
| wr_protect | output | 1 | Write protection held |
| batt_sel | output | 1 | Battery supply selected |

## Verification
The bench builds the gate with RECOVER_CYCLES set to 6 rather than the default of about a million. This brings the full recovery window and its restart case within a few dozen cycles. The exact release edge can then be checked on both sides. With the short window, the bench can also walk power-fail in the middle of a write, request rejection during recovery, and the write-into-read hand-off within one short run.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
  typedef struct packed {
    logic wr;
    logic rd;
  } bus_req_t;
endpackage

// File: rtl/pwr_recovery.sv
module pwr_recovery #(
  parameter int RECOVER_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_ok,
  output logic prot
);
  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RECOVER_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot  <= 1'b1;
      cnt_q <= '0;
    end else if (!vdd_ok) begin
      prot  <= 1'b1;
      cnt_q <= '0;
    end else if (prot) begin
      if (cnt_q == LAST) prot <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bus_decode.sv
module bus_decode
  import pwrfail_pkg::*;
(
  input  logic     en_n,
  input  logic     en,
  input  logic     oe_n,
  input  logic     wr_n,
  input  logic     vdd_ok,
  input  logic     prot,
  output bus_req_t req
);
  logic sel, live;

  always_comb begin
    sel    = !en_n && en;
    live   = vdd_ok && !prot;
    req.wr = sel && !wr_n && live;
    req.rd = sel && wr_n && !oe_n && live;
  end
endmodule

// File: rtl/bus_strobes.sv
module bus_strobes
  import pwrfail_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_req_t req,
  input  logic     vdd_ok,
  output logic     wr_active,
  output logic     wr_start,
  output logic     wr_commit,
  output logic     drive_en,
  output logic     rd_start
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_active <= 1'b0;
      wr_start  <= 1'b0;
      wr_commit <= 1'b0;
      drive_en  <= 1'b0;
      rd_start  <= 1'b0;
    end else begin
      wr_active <= req.wr;
      wr_start  <= req.wr && !wr_active;
      wr_commit <= wr_active && !req.wr && vdd_ok;
      drive_en  <= req.rd;
      rd_start  <= req.rd && !drive_en;
    end
  end
endmodule

// File: rtl/pwrfail_bus_gate.sv
module pwrfail_bus_gate
  import pwrfail_pkg::*;
#(
  parameter int RECOVER_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic en,
  input  logic oe_n,
  input  logic wr_n,
  input  logic vdd_ok,
  input  logic vdd_swo_ok,
  output logic wr_active,
  output logic wr_start,
  output logic wr_commit,
  output logic drive_en,
  output logic rd_start,
  output logic wr_protect,
  output logic batt_sel
);
  bus_req_t req;

  pwr_recovery #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_rec (
    .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .prot(wr_protect)
  );

  bus_decode u_dec (
    .en_n(en_n), .en(en), .oe_n(oe_n), .wr_n(wr_n),
    .vdd_ok(vdd_ok), .prot(wr_protect), .req(req)
  );

  bus_strobes u_stb (
    .clk(clk), .rst_n(rst_n), .req(req), .vdd_ok(vdd_ok),
    .wr_active(wr_active), .wr_start(wr_start), .wr_commit(wr_commit),
    .drive_en(drive_en), .rd_start(rd_start)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) batt_sel <= 1'b1;
    else        batt_sel <= !vdd_swo_ok;
  end
endmodule

// File: rtl/pwrfail_bus_gate_chk.sv
module pwrfail_bus_gate_chk #(
  parameter int RECOVER_CYCLES = 1000000
) (
  input logic clk,
  input logic rst_n,
  input logic vdd_ok,
  input logic vdd_swo_ok,
  input logic wr_active,
  input logic wr_start,
  input logic wr_commit,
  input logic drive_en,
  input logic rd_start,
  input logic wr_protect,
  input logic batt_sel
);
  localparam int GW = $clog2(RECOVER_CYCLES + 1) + 1;
  localparam logic [GW-1:0] SAT = GW'(RECOVER_CYCLES);

  logic [GW-1:0] good_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          good_q <= '0;
    else if (!vdd_ok)    good_q <= '0;
    else if (good_q != SAT) good_q <= good_q + 1'b1;
  end

  a_r2_start_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> wr_active);
  a_r3_commit_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wr_commit |-> !wr_active && $past(wr_active));
  a_r5_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && wr_active));
  a_r6_dead_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(vdd_ok) |->
      wr_protect && !wr_active && !wr_start && !drive_en && !rd_start);
  a_r7_no_commit_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wr_commit |-> $past(vdd_ok));
  a_r8_release_window: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(wr_protect) |-> good_q == SAT);
  a_r8_no_access_protected: assert property (@(posedge clk) disable iff (!rst_n)
    wr_protect |-> !wr_active && !drive_en);
  a_r9_batt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> batt_sel == !$past(vdd_swo_ok));
endmodule

bind pwrfail_bus_gate pwrfail_bus_gate_chk #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vdd_ok(vdd_ok), .vdd_swo_ok(vdd_swo_ok),
  .wr_active(wr_active), .wr_start(wr_start), .wr_commit(wr_commit),
  .drive_en(drive_en), .rd_start(rd_start), .wr_protect(wr_protect),
  .batt_sel(batt_sel)
);

// File: tb/test_pwrfail_bus_gate.sv
`timescale 1ns/1ps
module test_pwrfail_bus_gate;
  localparam int REC = 6;
  localparam int NV  = 13;
  // {en_n,en,oe_n,wr_n,vdd_ok,vdd_swo_ok} , {wr_active,wr_start,wr_commit,drive_en,rd_start,wr_protect,batt_sel}
  localparam logic [12:0] VEC [NV] = '{
    13'b111111_0000000, // idle
    13'b010111_0001100, // R4 read begins
    13'b010111_0001000, // R4 read held
    13'b010011_1100000, // R5 wr_n low drops drive, R2 write starts
    13'b010011_1000000, // R2 write held
    13'b110011_0010000, // R3 end by en_n
    13'b111111_0000000, // idle
    13'b000011_0000000, // not selected
    13'b010011_1100000, // R5 enable with wr_n low: write, no drive
    13'b010111_0011100, // R3 end by wr_n, read follows
    13'b011111_0000000, // R4 oe_n high ends drive
    13'b111110_0000001, // R9 switchover low
    13'b111111_0000000  // R9 switchover back
  };

  logic clk = 0, rst_n = 0;
  logic en_n = 1, en = 0, oe_n = 1, wr_n = 1, vdd_ok = 0, vdd_swo_ok = 0;
  logic wr_active, wr_start, wr_commit, drive_en, rd_start, wr_protect, batt_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwrfail_bus_gate #(.RECOVER_CYCLES(REC)) i_pwrfail_bus_gate (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .en(en), .oe_n(oe_n), .wr_n(wr_n),
    .vdd_ok(vdd_ok), .vdd_swo_ok(vdd_swo_ok), .wr_active(wr_active),
    .wr_start(wr_start), .wr_commit(wr_commit), .drive_en(drive_en),
    .rd_start(rd_start), .wr_protect(wr_protect), .batt_sel(batt_sel)
  );

  function automatic logic [6:0] outs();
    return {wr_active, wr_start, wr_commit, drive_en, rd_start, wr_protect, batt_sel};
  endfunction

  function automatic string row_tag(int i);
    case (i)
      1, 2, 10: return "R4";
      3, 8:     return "R5";
      4:        return "R2";
      5, 9:     return "R3";
      11, 12:   return "R9";
      default:  return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_in(logic [5:0] v);
    {en_n, en, oe_n, wr_n, vdd_ok, vdd_swo_ok} = v;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_in(6'b111111);
    repeat (3) @(negedge clk);
    chk("R1 reset held", outs(), 7'b0000011);
    rst_n = 1;
    chk("R1 after release", outs(), 7'b0000011);
    // R8 recovery from reset
    for (int k = 0; k < REC - 1; k++) step();
    chk("R8 still protected", outs(), 7'b0000010);
    step();
    chk("R8 released", outs(), 7'b0000000);

    for (int i = 0; i < NV; i++) begin
      drive_in(VEC[i][12:7]);
      step();
      chk(row_tag(i), outs(), VEC[i][6:0]);
    end

    // R7 power fail mid-write
    drive_in(6'b011011); step();
    chk("R2 write before fail", outs(), 7'b1100000);
    vdd_ok = 0; step();
    chk("R7 abort no commit", outs(), 7'b0000010);
    // R6 inputs ignored while supply low
    drive_in(6'b010101); step();
    chk("R6 read ignored", outs(), 7'b0000010);
    drive_in(6'b011001); step();
    chk("R6 write ignored", outs(), 7'b0000010);

    // R8 restart of the count
    drive_in(6'b111111);
    for (int k = 0; k < 3; k++) step();
    vdd_ok = 0; step();
    chk("R8 dip keeps protect", outs(), 7'b0000010);
    vdd_ok = 1; step();
    drive_in(6'b010111); step();
    chk("R8 read ignored in recovery", outs(), 7'b0000010);
    drive_in(6'b111111);
    for (int k = 0; k < REC - 3; k++) step();
    chk("R8 restart not yet released", outs(), 7'b0000010);
    step();
    chk("R8 restart released", outs(), 7'b0000000);
    drive_in(6'b011011); step();
    chk("R2 write after recovery", outs(), 7'b1100000);
    drive_in(6'b001011); step();
    chk("R3 end by en low", outs(), 7'b0010000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule